// File: doc/BRIEF.md
# Adaptive Thermal Throttle Controller

This block decides how far the performance point of a die must be pulled down when it runs hot. It reads a digital temperature-margin value in which zero means the die has reached its activation temperature, and a one-millisecond tick from elsewhere in the chip. From these it drives a hot indication, the performance-step index that the clock and voltage control should use, and a sticky critical flag. Step index 0 is the lowest performance point and `NUM_STEPS-1` the highest.

While the margin is non-zero the block passes the software-requested step through. When the margin reaches zero it enters a first throttle stage and lowers the step by one. If the margin is still zero at the next millisecond tick, it enters a second stage and lowers the step by one more. A counter then times how long both stages have been in force. If the die stays hot beyond `CRIT_MS` further ticks, the critical flag is raised. It stays raised until software clears it with a write-one-to-clear access. Once the margin is non-zero again, the step climbs back one level per tick until it reaches the request.

A configuration word holds the activation temperature in bits 23:16 and a temperature offset in bits 15:8. The block reports both values, together with the effective trip temperature (activation minus offset, floored at zero). All pins are plain control and status signals: there is no data stream and no back-pressure.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: When idle and `margin_i` reads zero at a rising edge, `hot_o` is 1 after that edge and `perf_step_o` drops one step below its previous value, never below 0.
- R2: `hot_o` is 1 exactly while a throttle stage is active; after a rising edge at which `margin_i` is non-zero, `hot_o` is 0.
- R3: In the first stage, a `ms_tick` seen while `margin_i` is still zero moves the block to the second stage and lowers `perf_step_o` by one more step, never below 0.
- R4: In the second stage, ticks seen while `margin_i` is zero are counted. `crit_o` is set on the tick that arrives after `CRIT_MS` ticks have already been counted. Leaving the second stage restarts the count from zero.
- R5: `crit_o` is sticky. It clears only at an edge where `crit_we`=1 and `crit_wdata`=1; a write of 0 has no effect. A set condition in the same cycle as a clear wins.
- R6: After throttling, while `margin_i` is non-zero, `perf_step_o` rises by one on each `ms_tick` until it equals the clamped request, and the block then returns to idle. A zero margin during recovery re-enters the first stage and lowers the step by one from its current value.
- R7: In idle, `perf_step_o` follows `req_step_i`, clamped to `NUM_STEPS-1`. The index never leaves the range 0..`NUM_STEPS-1`.
- R8: `cfg_we`=1 loads the activation temperature from `cfg_wdata[23:16]` and the offset from `cfg_wdata[15:8]`; the other bits are ignored. Without `cfg_we` both values hold. After reset they are `ACT_DEFAULT` (100) and 0.
- R9: `trip_temp_o` equals the activation temperature minus the offset, or 0 when the offset is larger.
- R10: After reset, `hot_o`=0, `crit_o`=0 and `perf_step_o`=`NUM_STEPS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| margin_i | input | MARGIN_W | Distance to activation temperature; zero means hot |
| req_step_i | input | $clog2(NUM_STEPS) | Software-requested performance step |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word (23:16 activation, 15:8 offset) |
| crit_we | input | 1 | Status write strobe for the critical flag |
| crit_wdata | input | 1 | Write 1 to clear the critical flag |
| hot_o | output | 1 | Throttling active |
| perf_step_o | output | $clog2(NUM_STEPS) | Granted performance step |
| crit_o | output | 1 | Sticky critical-temperature flag |
| act_temp_o | output | 8 | Activation temperature |
| temp_offset_o | output | 8 | Temperature offset |
| trip_temp_o | output | 8 | Activation minus offset, floored at 0 |

## Verification
The bench builds the block with `NUM_STEPS`=6 and `CRIT_MS`=3. With six steps a 3-bit request can exceed the top step, so the clamp in R7 can be reached, and a request of 0 drives the lowest-step floor during both throttle drops. A three-tick critical window lets the bench reach the exact tick on which the flag sets, restart the count by cooling briefly, and land a clear on a set cycle within a few dozen clocks.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STAGE1  = 2'd1,
    ST_STAGE2  = 2'd2,
    ST_RECOVER = 2'd3
  } thr_state_e;

  localparam int unsigned TEMP_W = 8;
  localparam int unsigned ACT_LSB = 16;
  localparam int unsigned OFS_LSB = 8;
endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg
  import thr_pkg::*;
#(
  parameter int unsigned ACT_DEFAULT = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [TEMP_W-1:0] act_temp,
  output logic [TEMP_W-1:0] temp_offset,
  output logic [TEMP_W-1:0] trip_temp
);
  logic unused_cfg_bits;
  assign unused_cfg_bits = ^{cfg_wdata[31:ACT_LSB+TEMP_W], cfg_wdata[OFS_LSB-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_temp    <= TEMP_W'(ACT_DEFAULT);
      temp_offset <= '0;
    end else if (cfg_we) begin
      act_temp    <= cfg_wdata[ACT_LSB +: TEMP_W];
      temp_offset <= cfg_wdata[OFS_LSB +: TEMP_W];
    end
  end

  assign trip_temp = (act_temp > temp_offset) ? (act_temp - temp_offset) : '0;

  // R8: values hold without a write strobe
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(act_temp) && $stable(temp_offset)));
endmodule

// File: rtl/thr_stage_fsm.sv
module thr_stage_fsm
  import thr_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 12,
  localparam int unsigned SW = $clog2(NUM_STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          hot_in,
  input  logic [SW-1:0] req_step,
  output thr_state_e    state,
  output logic [SW-1:0] perf_step
);
  localparam logic [SW-1:0] MAX_STEP = SW'(NUM_STEPS - 1);

  thr_state_e    nxt_state;
  logic [SW-1:0] nxt_step;
  logic [SW-1:0] req_c;
  logic [SW-1:0] step_dn;

  assign req_c   = (req_step > MAX_STEP) ? MAX_STEP : req_step;
  assign step_dn = (perf_step == '0) ? '0 : perf_step - SW'(1);

  always_comb begin
    nxt_state = state;
    nxt_step  = perf_step;
    case (state)
      ST_IDLE: begin
        if (hot_in) begin
          nxt_state = ST_STAGE1;
          nxt_step  = step_dn;
        end else begin
          nxt_step = req_c;
        end
      end
      ST_STAGE1: begin
        if (!hot_in) begin
          nxt_state = ST_RECOVER;
        end else if (ms_tick) begin
          nxt_state = ST_STAGE2;
          nxt_step  = step_dn;
        end
      end
      ST_STAGE2: begin
        if (!hot_in) nxt_state = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (hot_in) begin
          nxt_state = ST_STAGE1;
          nxt_step  = step_dn;
        end else if (perf_step >= req_c) begin
          nxt_state = ST_IDLE;
          nxt_step  = req_c;
        end else if (ms_tick) begin
          nxt_step = perf_step + SW'(1);
        end
      end
      default: nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      perf_step <= MAX_STEP;
    end else begin
      state     <= nxt_state;
      perf_step <= nxt_step;
    end
  end

  // R3: a tick while still hot in stage one drops one more step
  p_second_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STAGE1 && hot_in && ms_tick) |=>
      (state == ST_STAGE2 &&
       ((perf_step + SW'(1) == $past(perf_step)) || (perf_step == '0 && $past(perf_step) == '0))));

  // R6: recovery climbs exactly one step per tick
  p_recover_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RECOVER && !hot_in && ms_tick && perf_step < req_c) |=>
      (perf_step == $past(perf_step) + SW'(1)));

  // R7: index stays in range
  p_step_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    perf_step <= MAX_STEP);
endmodule

// File: rtl/thr_crit_timer.sv
module thr_crit_timer #(
  parameter int unsigned CRIT_MS = 20,
  localparam int unsigned CW = $clog2(CRIT_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic both_active,
  input  logic hot_in,
  input  logic clr,
  output logic crit
);
  localparam logic [CW-1:0] LIMIT = CW'(CRIT_MS);

  logic [CW-1:0] dwell;
  logic          armed;
  logic          set_now;

  assign armed   = both_active && hot_in;
  assign set_now = armed && ms_tick && (dwell == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell <= '0;
    end else if (!armed) begin
      dwell <= '0;
    end else if (ms_tick && dwell != LIMIT) begin
      dwell <= dwell + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crit <= 1'b0;
    else if (set_now) crit <= 1'b1;
    else if (clr)     crit <= 1'b0;
  end

  // R5: flag holds unless cleared
  p_crit_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crit && !clr) |=> crit);

  // R4: flag only rises on a tick while both stages are in force and hot
  p_crit_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crit) |-> $past(both_active && hot_in && ms_tick));
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int unsigned NUM_STEPS   = 12,
  parameter int unsigned MARGIN_W    = 8,
  parameter int unsigned CRIT_MS     = 20,
  parameter int unsigned ACT_DEFAULT = 100,
  localparam int unsigned SW = $clog2(NUM_STEPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ms_tick,
  input  logic [MARGIN_W-1:0] margin_i,
  input  logic [SW-1:0]       req_step_i,
  input  logic                cfg_we,
  input  logic [31:0]         cfg_wdata,
  input  logic                crit_we,
  input  logic                crit_wdata,
  output logic                hot_o,
  output logic [SW-1:0]       perf_step_o,
  output logic                crit_o,
  output logic [7:0]          act_temp_o,
  output logic [7:0]          temp_offset_o,
  output logic [7:0]          trip_temp_o
);
  thr_state_e st;
  logic       at_limit;

  assign at_limit = (margin_i == '0);

  thr_cfg_reg #(.ACT_DEFAULT(ACT_DEFAULT)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .act_temp    (act_temp_o),
    .temp_offset (temp_offset_o),
    .trip_temp   (trip_temp_o)
  );

  thr_stage_fsm #(.NUM_STEPS(NUM_STEPS)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .hot_in    (at_limit),
    .req_step  (req_step_i),
    .state     (st),
    .perf_step (perf_step_o)
  );

  thr_crit_timer #(.CRIT_MS(CRIT_MS)) u_crit (
    .clk         (clk),
    .rst_n       (rst_n),
    .ms_tick     (ms_tick),
    .both_active (st == ST_STAGE2),
    .hot_in      (at_limit),
    .clr         (crit_we && crit_wdata),
    .crit        (crit_o)
  );

  assign hot_o = (st == ST_STAGE1) || (st == ST_STAGE2);

  // R1: zero margin in idle raises the hot indication next cycle
  p_hot_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && at_limit) |=> hot_o);

  // R2: a non-zero margin drops the hot indication next cycle
  p_hot_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !at_limit |=> !hot_o);
endmodule

// File: tb/sim_thermal_throttle_ctrl.sv
module sim_thermal_throttle_ctrl;
  localparam int unsigned NS = 6;
  localparam int unsigned CM = 3;
  localparam int unsigned SW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ms_tick = 1'b0;
  logic [7:0]    margin = 8'd50;
  logic [SW-1:0] req = SW'(5);
  logic          cfg_we = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic          crit_we = 1'b0;
  logic          crit_wdata = 1'b0;
  logic          hot;
  logic [SW-1:0] step;
  logic          crit;
  logic [7:0]    act, ofs, trip;

  always #5 clk = ~clk;

  thermal_throttle_ctrl #(.NUM_STEPS(NS), .CRIT_MS(CM)) u0 (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .margin_i(margin),
    .req_step_i(req), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .crit_we(crit_we), .crit_wdata(crit_wdata), .hot_o(hot),
    .perf_step_o(step), .crit_o(crit), .act_temp_o(act),
    .temp_offset_o(ofs), .trip_temp_o(trip)
  );

  typedef struct {
    string tag;
    logic  hot;
    int    step;
    logic  crit;
    int    trip;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   exp_trip = 100;
  bit   done = 1'b0;

  logic        nx_cfg_we = 1'b0;
  logic [31:0] nx_cfg_data = '0;
  logic        nx_clr_we = 1'b0;
  logic        nx_clr_bit = 1'b0;

  task automatic cmp(input exp_t e);
    n_chk++;
    if (hot !== e.hot || int'(step) != e.step || crit !== e.crit || int'(trip) != e.trip) begin
      n_bad++;
      $display("FAIL %s: actual hot=%0b step=%0d crit=%0b trip=%0d expected hot=%0b step=%0d crit=%0b trip=%0d",
               e.tag, hot, step, crit, trip, e.hot, e.step, e.crit, e.trip);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the state expected after the next edge
  task automatic cyc(input string tag, input bit tk, input int mg, input int rq,
                     input bit ehot, input int estep, input bit ecrit);
    exp_t e;
    @(negedge clk);
    ms_tick    = tk;
    margin     = 8'(mg);
    req        = SW'(rq);
    cfg_we     = nx_cfg_we;
    cfg_wdata  = nx_cfg_data;
    crit_we    = nx_clr_we;
    crit_wdata = nx_clr_bit;
    nx_cfg_we  = 1'b0;
    nx_clr_we  = 1'b0;
    nx_clr_bit = 1'b0;
    e.tag = tag; e.hot = ehot; e.step = estep; e.crit = ecrit; e.trip = exp_trip;
    q.push_back(e);
  endtask

  // monitor: compares each queued item just after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) cmp(q.pop_front());
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    r.tag = "R10 reset state"; r.hot = 0; r.step = NS - 1; r.crit = 0; r.trip = 100;
    cmp(r);

    cyc("R7 idle follows request",   0, 50, 5, 0, 5, 0);
    cyc("R7 request clamped",        0, 50, 7, 0, 5, 0);
    cyc("R7 idle follows lower",     0, 50, 3, 0, 3, 0);
    cyc("R1 first drop",             0,  0, 3, 1, 2, 0);
    cyc("R2 hot held without tick",  0,  0, 3, 1, 2, 0);
    cyc("R3 second drop",            1,  0, 3, 1, 1, 0);
    for (int i = 0; i < CM; i++) cyc("R4 counting", 1, 0, 3, 1, 1, 0);
    cyc("R4 critical set",           1,  0, 3, 1, 1, 1);
    cyc("R2 hot drops",              0, 20, 3, 0, 1, 1);
    cyc("R6 waits for tick",         0, 20, 3, 0, 1, 1);
    cyc("R6 up one",                 1, 20, 3, 0, 2, 1);
    cyc("R6 up two",                 1, 20, 3, 0, 3, 1);
    cyc("R6 back to idle",           0, 20, 3, 0, 3, 1);
    cyc("R7 idle follows again",     0, 20, 5, 0, 5, 1);
    nx_clr_we = 1'b1; nx_clr_bit = 1'b0;
    cyc("R5 zero write ignored",     0, 50, 5, 0, 5, 1);
    nx_clr_we = 1'b1; nx_clr_bit = 1'b1;
    cyc("R5 write one clears",       0, 50, 5, 0, 5, 0);

    cyc("R7 request zero",           0, 50, 0, 0, 0, 0);
    cyc("R1 floor on first drop",    0,  0, 0, 1, 0, 0);
    cyc("R3 floor on second drop",   1,  0, 0, 1, 0, 0);
    cyc("R6 recover at floor",       0, 50, 0, 0, 0, 0);
    cyc("R6 idle at floor",          0, 50, 0, 0, 0, 0);

    cyc("R7 request four",           0, 50, 4, 0, 4, 0);
    cyc("R1 drop from four",         0,  0, 4, 1, 3, 0);
    cyc("R3 drop to two",            1,  0, 4, 1, 2, 0);
    for (int i = 0; i < CM; i++) cyc("R4 count before cooling", 1, 0, 4, 1, 2, 0);
    cyc("R2 cooled briefly",         0, 50, 4, 0, 2, 0);
    cyc("R6 climb one",              1, 50, 4, 0, 3, 0);
    cyc("R6 reheat drops from current", 0, 0, 4, 1, 2, 0);
    cyc("R3 stage two again",        1,  0, 4, 1, 1, 0);
    for (int i = 0; i < CM; i++) cyc("R4 count restarted", 1, 0, 4, 1, 1, 0);
    cyc("R4 critical after restart", 1,  0, 4, 1, 1, 1);
    nx_clr_we = 1'b1; nx_clr_bit = 1'b1;
    cyc("R5 set wins over clear",    1,  0, 4, 1, 1, 1);
    nx_clr_we = 1'b1; nx_clr_bit = 1'b1;
    cyc("R5 clear while hot",        0,  0, 4, 1, 1, 0);

    nx_cfg_we = 1'b1; nx_cfg_data = {8'hA5, 8'd90, 8'd10, 8'hFF};
    exp_trip = 80;
    cyc("R8 R9 config write",        0, 50, 4, 0, 1, 0);
    nx_cfg_data = {8'h00, 8'd20, 8'd1, 8'h00};
    cyc("R8 no strobe holds",        0, 50, 4, 0, 1, 0);
    nx_cfg_we = 1'b1; nx_cfg_data = {8'h00, 8'd5, 8'd10, 8'h00};
    exp_trip = 0;
    cyc("R9 trip floors at zero",    0, 50, 4, 0, 1, 0);

    @(negedge clk);
    ms_tick = 1'b0;
    repeat (3) @(negedge clk);
    if (act !== 8'd5 || ofs !== 8'd10) begin
      n_bad++;
      $display("FAIL R8 field positions: actual act=%0d ofs=%0d expected act=5 ofs=10", act, ofs);
    end
    n_chk++;
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule